// File: doc/BRIEF.md
# Stereo Soft-Mute Attenuator

This block sits in the digital audio path ahead of the interpolation stages. It takes one left and one right 24-bit two's-complement sample per frame, marked by a one-cycle sample strobe, and scales each by its own 10-bit linear gain code (1024 steps, code/1024 of full scale). The gain actually applied never jumps. On every strobe it moves one code toward its target and stops there. This keeps volume changes and muting free of clicks.

Muting has two sources. A hardware mute input silences both channels. Each channel also has its own soft-mute bit, which silences only that channel. When muted, the target is zero, so the channel fades out over at most 1023 frames. Beside the gain path, a watcher on each input channel counts consecutive all-zero samples in frame periods. It raises that channel's flag once more than 1024 have arrived in a row.

Top module: `stereo_softgain`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `smp_valid` high and low otherwise; `out_left`/`out_right` change only after a strobe.
- R2: On a strobe, each output becomes floor(sample × g / 1024), where g is the channel's applied gain before that strobe's step (0..1023).
- R3: On each strobe the applied gain moves by exactly one code toward its target and holds once equal; without a strobe it does not change. Unmuted, the target is the channel's gain code.
- R4: While `hw_mute` is 1, the target of both channels is 0.
- R5: `mute_left` (or `mute_right`) at 1 sets that channel's target to 0 and leaves the other channel's ramp unaffected.
- R6: A channel's zero flag rises on the strobe that delivers its 1025th consecutive zero sample (more than 1024 in a row), not earlier.
- R7: A nonzero sample clears its channel's run count and zero flag on that same strobe; the run count saturates, so the flag stays high through any longer run of zeros.
- R8: The two zero flags are independent: each depends only on its own channel's samples.
- R9: Reset (synchronous, active-high `rst`) sets both applied gains to 1023, clears outputs, `out_valid` and both zero flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new stereo frame |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| gain_left | input | 10 | Left gain code, linear, 1023 = full scale |
| gain_right | input | 10 | Right gain code |
| mute_left | input | 1 | Left soft-mute bit |
| mute_right | input | 1 | Right soft-mute bit |
| hw_mute | input | 1 | Mute both channels |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| out_valid | output | 1 | Scaled samples updated |
| zero_left | output | 1 | Left channel zero-run flag |
| zero_right | output | 1 | Right channel zero-run flag |

## Verification
The scaling is tried with the extreme samples 0x7FFFFF and 0x800000, with -1 and with small odd values. Negative operands separate floor rounding from truncation toward zero. A gain change, a hardware mute, and a soft mute on one channel only are each followed strobe by strobe through the full ramp. Strobes come both back to back and with idle gaps, which shows that the ramp advances per frame and not per clock. A left-only zero run of 1100 frames with the right channel kept busy shows the exact rise frame, the saturation and the independence of the channels. A single nonzero sample then shows the immediate clear.

// File: rtl/stereo_softgain_pkg.sv
package stereo_softgain_pkg;
    localparam int SMP_W    = 24;
    localparam int GAIN_W   = 10;
    localparam int ZERO_RUN = 1024;
    localparam int NCH      = 2;

    typedef logic signed [SMP_W-1:0] sample_t;
    typedef logic [GAIN_W-1:0]       gain_t;

    typedef struct packed {
        gain_t code;
        logic  mute;
    } chan_ctl_t;

    // one code toward the target, or stay
    function automatic gain_t gain_step(input gain_t cur, input gain_t tgt);
        if (cur < tgt)      return cur + gain_t'(1);
        else if (cur > tgt) return cur - gain_t'(1);
        else                return cur;
    endfunction
endpackage

// File: rtl/gain_ramp.sv
module gain_ramp
    import stereo_softgain_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      step_en,
    input  chan_ctl_t ctl,
    input  logic      force_mute,
    output gain_t     gain
);
    gain_t target;

    always_comb begin
        target = (ctl.mute || force_mute) ? '0 : ctl.code;
    end

    always_ff @(posedge clk) begin
        if (rst)          gain <= '1;
        else if (step_en) gain <= gain_step(gain, target);
    end
endmodule

// File: rtl/sample_scaler.sv
module sample_scaler
    import stereo_softgain_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  sample_t din,
    input  gain_t   gain,
    output sample_t dout
);
    localparam int PROD_W = SMP_W + GAIN_W + 1;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;

    always_comb begin
        prod    = PROD_W'(din) * $signed({1'b0, gain});
        shifted = prod >>> GAIN_W;
    end

    always_ff @(posedge clk) begin
        if (rst)     dout <= '0;
        else if (en) dout <= shifted[SMP_W-1:0];
    end
endmodule

// File: rtl/zero_watch.sv
module zero_watch
    import stereo_softgain_pkg::*;
#(
    parameter int RUN_LEN = ZERO_RUN
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  sample_t din,
    output logic    flag
);
    localparam int CNT_MAX = RUN_LEN + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] run_nxt;

    always_comb begin
        if (run_cnt == CNT_W'(CNT_MAX)) run_nxt = run_cnt;
        else                            run_nxt = run_cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            flag    <= 1'b0;
        end else if (en) begin
            if (din == '0) begin
                run_cnt <= run_nxt;
                flag    <= (run_nxt == CNT_W'(CNT_MAX));
            end else begin
                run_cnt <= '0;
                flag    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/stereo_softgain.sv
module stereo_softgain
    import stereo_softgain_pkg::*;
#(
    parameter int RUN_LEN = ZERO_RUN
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic [SMP_W-1:0]        in_left,
    input  logic [SMP_W-1:0]        in_right,
    input  logic [GAIN_W-1:0]       gain_left,
    input  logic [GAIN_W-1:0]       gain_right,
    input  logic                    mute_left,
    input  logic                    mute_right,
    input  logic                    hw_mute,
    output logic [SMP_W-1:0]        out_left,
    output logic [SMP_W-1:0]        out_right,
    output logic                    out_valid,
    output logic                    zero_left,
    output logic                    zero_right
);
    sample_t   smp_in   [NCH];
    sample_t   smp_out  [NCH];
    chan_ctl_t ctl      [NCH];
    gain_t     gain_now [NCH];
    logic      zflag    [NCH];

    always_comb begin
        smp_in[0] = in_left;
        smp_in[1] = in_right;
        ctl[0]    = '{code: gain_left,  mute: mute_left};
        ctl[1]    = '{code: gain_right, mute: mute_right};
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        gain_ramp u_ramp (
            .clk        (clk),
            .rst        (rst),
            .step_en    (smp_valid),
            .ctl        (ctl[c]),
            .force_mute (hw_mute),
            .gain       (gain_now[c])
        );

        sample_scaler u_scale (
            .clk  (clk),
            .rst  (rst),
            .en   (smp_valid),
            .din  (smp_in[c]),
            .gain (gain_now[c]),
            .dout (smp_out[c])
        );

        zero_watch #(.RUN_LEN(RUN_LEN)) u_zero (
            .clk  (clk),
            .rst  (rst),
            .en   (smp_valid),
            .din  (smp_in[c]),
            .flag (zflag[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= smp_valid;
    end

    assign out_left   = smp_out[0];
    assign out_right  = smp_out[1];
    assign zero_left  = zflag[0];
    assign zero_right = zflag[1];
endmodule

// File: rtl/stereo_softgain_chk.sv
module stereo_softgain_chk
    import stereo_softgain_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        smp_valid,
    input logic [23:0] in_left,
    input logic [23:0] in_right,
    input logic        mute_left,
    input logic        mute_right,
    input logic        hw_mute,
    input logic [23:0] out_left,
    input logic        out_valid,
    input logic        zero_left,
    input logic        zero_right,
    input gain_t       gain_l,
    input gain_t       gain_r
);
    p_valid_after_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> out_valid);
    p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !out_valid && $stable(out_left));

    p_step_size_r3: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> (int'(gain_l) - int'($past(gain_l)) <= 1) &&
                      (int'($past(gain_l)) - int'(gain_l) <= 1));
    p_gain_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(gain_l) && $stable(gain_r));

    p_hw_mute_fall_r4: assert property (@(posedge clk) disable iff (rst)
        smp_valid && hw_mute |=> (gain_l <= $past(gain_l)) && (gain_r <= $past(gain_r)));

    p_soft_mute_left_r5: assert property (@(posedge clk) disable iff (rst)
        smp_valid && mute_left |=> gain_l <= $past(gain_l));
    p_soft_mute_right_r5: assert property (@(posedge clk) disable iff (rst)
        smp_valid && mute_right |=> gain_r <= $past(gain_r));

    p_zero_rise_left_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(zero_left) |-> $past(smp_valid && in_left == '0));

    p_zero_clear_left_r7: assert property (@(posedge clk) disable iff (rst)
        smp_valid && in_left != '0 |=> !zero_left);
    p_zero_clear_right_r7: assert property (@(posedge clk) disable iff (rst)
        smp_valid && in_right != '0 |=> !zero_right);

    p_reset_gain_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> gain_l == '1 && gain_r == '1 && !zero_left && !zero_right);
endmodule

bind stereo_softgain stereo_softgain_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .in_left    (in_left),
    .in_right   (in_right),
    .mute_left  (mute_left),
    .mute_right (mute_right),
    .hw_mute    (hw_mute),
    .out_left   (out_left),
    .out_valid  (out_valid),
    .zero_left  (zero_left),
    .zero_right (zero_right),
    .gain_l     (gain_now[0]),
    .gain_r     (gain_now[1])
);

// File: tb/sim_stereo_softgain.sv
module sim_stereo_softgain;
    localparam int CLK_PERIOD = 10;
    localparam int RUN        = 1024;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [23:0] in_left = '0, in_right = '0;
    logic [9:0]  gain_left = 10'd1023, gain_right = 10'd1023;
    logic        mute_left = 1'b0, mute_right = 1'b0, hw_mute = 1'b0;
    logic [23:0] out_left, out_right;
    logic        out_valid, zero_left, zero_right;

    stereo_softgain u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .in_left(in_left), .in_right(in_right),
        .gain_left(gain_left), .gain_right(gain_right),
        .mute_left(mute_left), .mute_right(mute_right), .hw_mute(hw_mute),
        .out_left(out_left), .out_right(out_right), .out_valid(out_valid),
        .zero_left(zero_left), .zero_right(zero_right)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    string ph = "R9";

    // behavioural reference state
    int m_gain [2];
    int m_run  [2];
    int m_out  [2];
    int m_zf   [2];
    int m_vld;

    function automatic int sx24(input logic [23:0] v);
        return int'($signed(v));
    endfunction

    function automatic int floor_scale(input int s, input int g);
        longint p, q;
        p = longint'(s) * longint'(g);
        q = p / 1024;
        if (p < 0 && q * 1024 != p) q = q - 1;
        return int'(q);
    endfunction

    task automatic model_edge();
        int smp [2];
        int code [2];
        int mt [2];
        smp[0] = sx24(in_left);  smp[1] = sx24(in_right);
        code[0] = int'(gain_left); code[1] = int'(gain_right);
        mt[0] = int'(mute_left | hw_mute); mt[1] = int'(mute_right | hw_mute);
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_gain[c] = 1023; m_run[c] = 0; m_out[c] = 0; m_zf[c] = 0;
            end
            m_vld = 0;
            return;
        end
        m_vld = int'(smp_valid);
        if (!smp_valid) return;
        for (int c = 0; c < 2; c++) begin
            int tgt;
            m_out[c] = floor_scale(smp[c], m_gain[c]);
            tgt = mt[c] ? 0 : code[c];
            if (m_gain[c] < tgt) m_gain[c]++;
            else if (m_gain[c] > tgt) m_gain[c]--;
            if (smp[c] == 0) begin
                if (m_run[c] <= RUN) m_run[c]++;
                m_zf[c] = (m_run[c] > RUN) ? 1 : 0;
            end else begin
                m_run[c] = 0; m_zf[c] = 0;
            end
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        chk("R1", "out_valid", int'(out_valid), m_vld);
        chk(ph, "out_left",  sx24(out_left),  m_out[0]);
        chk(ph, "out_right", sx24(out_right), m_out[1]);
        chk(ph, "zero_left",  int'(zero_left),  m_zf[0]);
        chk(ph, "zero_right", int'(zero_right), m_zf[1]);
    endtask

    // inputs are set after a negedge; one clock; compare at the next negedge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cycles++;
        compare_all();
    endtask

    task automatic frame(input logic [23:0] l, input logic [23:0] r, input int gap);
        in_left = l; in_right = r; smp_valid = 1'b1;
        tick();
        smp_valid = 1'b0;
        for (int i = 0; i < gap; i++) tick();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick();
        rst = 1'b0;
        ph = "R9";                       // reset state seen at the ports
        tick();

        ph = "R2";                       // full-scale scaling, floor rounding
        frame(24'h7FFFFF, 24'h800000, 0);
        frame(24'hFFFFFF, 24'h000001, 0);
        frame(24'h000401, 24'hFFFBFF, 2);
        frame(24'h123456, 24'hEDCBA9, 0);

        ph = "R3";                       // ramp down to a lower code, idle gaps hold
        gain_left = 10'd1000; gain_right = 10'd1010;
        for (int i = 0; i < 30; i++) frame(24'h400000, 24'hC00001, i % 3);
        gain_left = 10'd1020;            // ramp back up
        for (int i = 0; i < 25; i++) frame(24'h3FFFFF, 24'h7FFFFF, 0);

        ph = "R4";                       // hardware mute fades both channels
        hw_mute = 1'b1;
        for (int i = 0; i < 1030; i++) frame(24'h7FFFFF, 24'h800000, 0);
        hw_mute = 1'b0;
        for (int i = 0; i < 40; i++) frame(24'h7FFFFF, 24'h800000, 0);

        ph = "R5";                       // soft mute left only
        mute_left = 1'b1;
        for (int i = 0; i < 60; i++) frame(24'h654321, 24'h654321, 0);
        mute_left = 1'b0;
        for (int i = 0; i < 10; i++) frame(24'h654321, 24'h654321, 0);

        ph = "R6";                       // left zero run, right busy (R8)
        for (int i = 0; i < 1100; i++) frame(24'h000000, 24'h000010, (i == 500) ? 3 : 0);
        ph = "R8";
        frame(24'h000000, 24'h000000, 0);
        ph = "R7";                       // single nonzero clears at once
        frame(24'h000001, 24'h000000, 0);
        frame(24'h000000, 24'h000000, 1);

        summary();
    end

    initial begin
        while (cycles < WATCHDOG) @(negedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
        summary();
    end
endmodule